// File: doc/BRIEF.md
# Transport Stream Packet Sync Acquisition

This block sits after the descrambler in a demodulator receive path. It takes one byte per strobe and finds where the fixed-length, FEC-protected transport packets begin. Each packet opens with a sync byte of 0x47. In every group of eight packets, one sync byte is sent bit-inverted as 0xB8. The inverted byte marks the start of a superframe.

The block starts out hunting. It takes any byte that matches either sync value as a candidate alignment. It then checks that a sync value recurs exactly one packet length later, and that the inverted value shows up once per group, in the same slot each time. Lock is declared only after several whole superframes have been confirmed. While locked, the framing counters flywheel through occasional corrupted sync bytes. A run of missed or misplaced sync bytes drops the block back to hunting.

Every accepted byte comes out one cycle later with three flags: packet start, superframe start and lock. Bit-phase search, depuncturing, Reed-Solomon decoding and descrambling are handled by other blocks.

Top module: `ts_sync_acq`

## Requirements
- R1: A byte is taken only in a cycle where `in_valid` is high. It appears on `out_byte` with `out_valid` high on the next cycle. Idle cycles produce `out_valid` low, leave the flags low and `out_lock` unchanged, and do not advance any position counter.
- R2: While `rst_n` is low, all outputs are 0. After reset the block is hunting and unlocked.
- R3: While hunting, the first accepted byte equal to 0x47 or 0xB8 becomes packet position 0 of a candidate alignment. A single match never gives lock. If the byte `PKT_LEN` accepted bytes later is not a sync value, the block returns to hunting. That byte is not itself taken as a new candidate.
- R4: While verifying, once an 0xB8 has been seen, each later 0xB8 must fall exactly `SF_PKTS` packets after the previous one, and every other packet start must hold 0x47. Any deviation returns the block to hunting. Before the first 0xB8, at most `SF_PKTS`-1 consecutive 0x47 packet starts are allowed; one more also returns the block to hunting.
- R5: `out_lock` rises together with the 0xB8 byte that completes `LOCK_SF` consecutive verified superframes after the first 0xB8. With the bench configuration, that is the packet `LOCK_SF`*`SF_PKTS` packets after the first inverted sync byte of the candidate.
- R6: `out_pkt_start` is high exactly on bytes at packet position 0 while locked, including the byte that causes lock. `out_sf_start` is high on those packet starts that are in the inverted-sync slot. Both are low on every other byte.
- R7: While locked, a packet start that does not hold the value expected for its slot counts as a miss. A wrong normal/inverted value counts as a miss too. `LOSS_MISSES` consecutive misses drop `out_lock` on the byte of the last miss, and the block returns to hunting. A correct sync byte clears the miss count.
- R8: While locked, a missed packet start still gets `out_pkt_start` (and `out_sf_start` in its slot). The framing keeps its position through misses that do not reach the loss threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte strobe |
| in_byte | input | 8 | Descrambled stream byte |
| out_valid | output | 1 | Output byte strobe, one cycle after `in_valid` |
| out_byte | output | 8 | Delayed copy of the accepted byte |
| out_pkt_start | output | 1 | Byte is a packet start while locked |
| out_sf_start | output | 1 | Byte is a superframe start while locked |
| out_lock | output | 1 | Framing is locked |

## Verification
The bench builds the block with a 6-byte packet, 4-packet superframes, lock after 2 superframes and loss after 3 misses. With these values every acquisition, rejection and loss sequence fits in a few hundred bytes, so every byte of each stream can be checked against the packet index computed in the bench. The sequences are: a clean stream with idle gaps, a false sync in the lead-in, an extra inverted sync during verification, suppressed inverted syncs that exhaust the normal-run limit, and a locked stream with sub-threshold misses followed by a misplaced inverted sync that completes the loss run.

// File: rtl/ts_sync_acq.sv
module ts_sync_acq #(
  parameter int PKT_LEN = 204,
  parameter int SF_PKTS = 8,
  parameter int LOCK_SF = 3,
  parameter int LOSS_MISSES = 4,
  parameter logic [7:0] SYNC_BYTE = 8'h47
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  output logic       out_valid,
  output logic [7:0] out_byte,
  output logic       out_pkt_start,
  output logic       out_sf_start,
  output logic       out_lock
);
  localparam int POS_W = (PKT_LEN > 1) ? $clog2(PKT_LEN) : 1;
  localparam int SF_W  = (SF_PKTS > 1) ? $clog2(SF_PKTS) : 1;
  localparam int LK_W  = (LOCK_SF > 1) ? $clog2(LOCK_SF) : 1;
  localparam int MS_W  = (LOSS_MISSES > 1) ? $clog2(LOSS_MISSES) : 1;
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(PKT_LEN - 1);
  localparam logic [SF_W-1:0]  SF_LAST  = SF_W'(SF_PKTS - 1);

  typedef enum logic [1:0] {HUNT, VERIFY, LOCKED} st_t;

  st_t              st, st_n;
  logic [POS_W-1:0] pos, pos_n;
  logic [SF_W-1:0]  sfi, sfi_n, nrm, nrm_n;
  logic             known, known_n;
  logic [LK_W-1:0]  done, done_n;
  logic [MS_W-1:0]  miss, miss_n;

  wire              is_norm  = (in_byte == SYNC_BYTE);
  wire              is_inv   = (in_byte == ~SYNC_BYTE);
  wire [POS_W-1:0]  cur      = (pos == POS_LAST) ? '0 : pos + 1'b1;
  wire              bnd      = (cur == '0);
  wire [SF_W-1:0]   nidx     = (sfi == SF_LAST) ? '0 : sfi + 1'b1;
  wire              want_inv = (nidx == '0);
  wire              sync_ok  = want_inv ? is_inv : is_norm;

  always_comb begin
    st_n    = st;
    pos_n   = pos;
    sfi_n   = sfi;
    nrm_n   = nrm;
    known_n = known;
    done_n  = done;
    miss_n  = miss;
    if (in_valid) begin
      unique case (st)
        HUNT: begin
          if (is_norm || is_inv) begin
            st_n    = VERIFY;
            pos_n   = '0;
            known_n = is_inv;
            sfi_n   = '0;
            nrm_n   = SF_W'(1);
            done_n  = '0;
          end
        end
        VERIFY: begin
          pos_n = cur;
          if (bnd) begin
            if (known) begin
              if (sync_ok) begin
                sfi_n = nidx;
                if (want_inv) begin
                  if (done == LK_W'(LOCK_SF - 1)) begin
                    st_n   = LOCKED;
                    miss_n = '0;
                  end else begin
                    done_n = done + 1'b1;
                  end
                end
              end else begin
                st_n = HUNT;
              end
            end else if (is_inv) begin
              known_n = 1'b1;
              sfi_n   = '0;
              done_n  = '0;
            end else if (is_norm && nrm != SF_LAST) begin
              nrm_n = nrm + 1'b1;
            end else begin
              st_n = HUNT;
            end
          end
        end
        LOCKED: begin
          pos_n = cur;
          if (bnd) begin
            sfi_n = nidx;
            if (sync_ok) miss_n = '0;
            else if (miss == MS_W'(LOSS_MISSES - 1)) st_n = HUNT;
            else miss_n = miss + 1'b1;
          end
        end
        default: st_n = HUNT;
      endcase
    end
  end

  wire pkt_n = in_valid && (st_n == LOCKED) && bnd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st            <= HUNT;
      pos           <= '0;
      sfi           <= '0;
      nrm           <= '0;
      known         <= 1'b0;
      done          <= '0;
      miss          <= '0;
      out_valid     <= 1'b0;
      out_byte      <= '0;
      out_pkt_start <= 1'b0;
      out_sf_start  <= 1'b0;
      out_lock      <= 1'b0;
    end else begin
      st            <= st_n;
      pos           <= pos_n;
      sfi           <= sfi_n;
      nrm           <= nrm_n;
      known         <= known_n;
      done          <= done_n;
      miss          <= miss_n;
      out_valid     <= in_valid;
      out_byte      <= in_valid ? in_byte : out_byte;
      out_pkt_start <= pkt_n;
      out_sf_start  <= pkt_n && want_inv;
      out_lock      <= (st_n == LOCKED);
    end
  end
endmodule

module ts_sync_acq_chk #(
  parameter logic [7:0] SYNC_BYTE = 8'h47
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [7:0] in_byte,
  input logic       out_valid,
  input logic [7:0] out_byte,
  input logic       out_pkt_start,
  input logic       out_sf_start,
  input logic       out_lock
);
  assert_echo_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_byte == $past(in_byte));
  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && $past(rst_n)) |-> ($stable(out_lock) && !out_pkt_start));
  assert_lock_on_inv_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_lock) |-> (out_sf_start && out_byte == ~SYNC_BYTE));
  assert_sf_in_pkt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_sf_start |-> out_pkt_start);
  assert_pkt_needs_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_pkt_start |-> (out_lock && out_valid));
  assert_drop_on_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_lock) |-> (out_valid && !out_pkt_start));
endmodule

bind ts_sync_acq ts_sync_acq_chk #(.SYNC_BYTE(SYNC_BYTE)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
  .out_valid(out_valid), .out_byte(out_byte), .out_pkt_start(out_pkt_start),
  .out_sf_start(out_sf_start), .out_lock(out_lock));

// File: tb/tb_ts_sync_acq.sv
module tb_ts_sync_acq;
  localparam int L = 6, SF = 4, LK = 2, LS = 3, LEAD = 3;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [7:0] in_byte = '0;
  logic out_valid, out_pkt_start, out_sf_start, out_lock;
  logic [7:0] out_byte;
  int errors = 0, checks = 0;
  bit finished = 1'b0;

  int ph, fk;
  logic [7:0] fv;
  bit pf [0:63];
  logic [7:0] pv [0:63];

  always #4 clk = ~clk;

  ts_sync_acq #(.PKT_LEN(L), .SF_PKTS(SF), .LOCK_SF(LK), .LOSS_MISSES(LS)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .out_valid(out_valid), .out_byte(out_byte), .out_pkt_start(out_pkt_start),
    .out_sf_start(out_sf_start), .out_lock(out_lock));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] byte_at(input int k);
    int q, p, o;
    if (k == fk) return fv;
    if (k < LEAD) return 8'(k + 1);
    q = k - LEAD; p = q / L; o = q % L;
    if (o != 0) return {4'h0, 4'(q)};
    if (pf[p]) return pv[p];
    return (p % SF == ph) ? 8'hB8 : 8'h47;
  endfunction

  task automatic setup(input int phase);
    ph = phase; fk = -1; fv = '0;
    for (int i = 0; i < 64; i++) begin pf[i] = 1'b0; pv[i] = '0; end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(!out_valid && !out_lock && !out_pkt_start && !out_sf_start && out_byte == 0,
        "R2 reset outputs", {out_valid, out_lock, out_pkt_start, out_sf_start}, 0);
    rst_n = 1'b1;
  endtask

  task automatic run(input int npkt, input int pon, input int poff, input bit gaps);
    for (int k = 0; k < LEAD + npkt * L; k++) begin
      int p;
      bit first, lk, pk, sf;
      logic [7:0] b;
      b = byte_at(k);
      p = (k < LEAD) ? -1 : (k - LEAD) / L;
      first = (k >= LEAD) && ((k - LEAD) % L == 0);
      lk = (p >= pon) && (p < poff);
      pk = first && lk;
      sf = pk && (p % SF == ph);
      in_valid = 1'b1; in_byte = b;
      @(negedge clk);
      in_valid = 1'b0;
      chk(out_valid && out_byte == b, "R1 byte echo", out_byte, b);
      chk(out_lock == lk, "R5/R7 lock", out_lock, lk);
      chk(out_pkt_start == pk, "R6/R8 packet start", out_pkt_start, pk);
      chk(out_sf_start == sf, "R6/R8 superframe start", out_sf_start, sf);
      if (gaps && (k % 5 == 4)) begin
        bit held;
        held = out_lock;
        repeat (2) @(negedge clk);
        chk(!out_valid && !out_pkt_start && out_lock == held, "R1 idle cycle",
            {out_valid, out_pkt_start, out_lock}, {2'b00, held});
      end
    end
  endtask

  initial begin
    setup(0);
    // R1 R5 R6: clean stream, idle gaps, first inverted sync in slot 2
    do_reset();
    setup(2);
    run(14, 2 + LK * SF, 99, 1'b1);
    // R3: false sync in lead-in delays lock by a superframe
    do_reset();
    setup(0); fk = 1; fv = 8'h47;
    run(14, 4 + LK * SF, 99, 1'b0);
    // R4: extra inverted sync during verification
    do_reset();
    setup(0); pf[2] = 1'b1; pv[2] = 8'hB8;
    run(14, 4 + LK * SF, 99, 1'b0);
    // R4: normal-run limit before first inverted sync
    do_reset();
    setup(0); pf[0] = 1'b1; pv[0] = 8'h47; pf[4] = 1'b1; pv[4] = 8'h47;
    run(18, 8 + LK * SF, 99, 1'b0);
    // R7 R8: two misses then good, then three misses incl. misplaced inverted sync
    do_reset();
    setup(0);
    pf[10] = 1'b1; pf[11] = 1'b1; pf[13] = 1'b1; pv[13] = 8'hB8;
    pf[14] = 1'b1; pf[15] = 1'b1;
    run(18, LK * SF, 15, 1'b0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule